// File: doc/BRIEF.md
# Instruction Prefix Decoder and Operand-Size Resolver

This block sits at the front of an instruction decoder. It accepts instruction bytes one per cycle over a valid/ready handshake. It gathers the legacy prefixes and an optional REX byte that lead up to a one-byte primary opcode. When the opcode arrives, it emits a single result record. The record holds the opcode byte, the resolved operand size, the resolved address size, the four REX extension bits, and an error flag for an over-long prefix run. All prefix state is then cleared for the next instruction.

Two inputs set the execution context. `long_mode` selects 64-bit mode. When it is low, the block runs in compatibility mode, and `seg_def32` gives the default width from the code segment. The operand size depends on the mode, on the 66h prefix, on REX.W and on the opcode class. In 64-bit mode, stack-class opcodes default to 64 bits, and REX.W=0 cannot bring them down to 32. The bytes 40h to 4Fh act as REX only in 64-bit mode. ModRM, SIB, displacement, immediate and escape-opcode handling belong to later stages. The context inputs are expected to change only between instructions.

Top module: `insn_prefix_resolver`

## Requirements
- R1: `byte_ready` is high whenever no result is pending or `res_ready` is high. While `res_valid` is high and `res_ready` is low, no byte is taken and every result output holds its value.
- R2: The bytes 66h, 67h, 26h, 2Eh, 36h, 3Eh, 64h, 65h, F0h, F2h and F3h are prefixes and produce no result. Any other accepted byte, apart from a REX byte in 64-bit mode, is an opcode. `res_valid` rises in the cycle after the opcode is taken, and `res_opcode` carries that byte.
- R3: Size codes on `res_op_size` and `res_ad_size` are 00 = 16-bit, 01 = 32-bit, 10 = 64-bit. In 64-bit mode an ordinary opcode gets 32 bits by default and 16 bits after a 66h prefix. REX.W=1 gives 64 bits, with or without 66h.
- R4: In 64-bit mode the stack-class opcodes get 64 bits by default and 16 bits with 66h alone. A REX byte with W=0 leaves them at 64 bits. The stack-class opcodes are 50h–5Fh, 68h, 6Ah, 8Fh, 9Ch, 9Dh, C8h and C9h.
- R5: In compatibility mode the bytes 40h–4Fh are opcodes, and all four REX outputs read 0.
- R6: In compatibility mode the operand size is 32 bits when `seg_def32` is 1 and 16 bits when it is 0. A 66h prefix selects the other of the two. The opcode class has no effect.
- R7: The address size is 64 bits in 64-bit mode and 32 bits there with 67h. In compatibility mode it follows `seg_def32`, and 67h selects the other width.
- R8: A REX byte supplies W, R, X and B from its bits 3, 2, 1 and 0. It counts only if it is the last prefix before the opcode: any legacy prefix after it clears all four bits. A later REX byte replaces an earlier one.
- R9: After each opcode, all prefix, REX and count state returns to its reset value. The next instruction sees only its own prefixes.
- R10: `res_pfx_err` is 1 when more than MAX_PFX (default 14) prefix bytes precede the opcode. REX bytes count toward this total. With exactly MAX_PFX prefix bytes the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = compatibility mode |
| seg_def32 | input | 1 | Code-segment default size in compatibility mode (1 = 32-bit) |
| byte_valid | input | 1 | Instruction byte present |
| byte_data | input | 8 | Instruction byte |
| byte_ready | output | 1 | Block accepts a byte this cycle |
| res_ready | input | 1 | Consumer takes the result |
| res_valid | output | 1 | Result record is valid |
| res_opcode | output | 8 | Primary opcode byte |
| res_op_size | output | 2 | Effective operand size code |
| res_ad_size | output | 2 | Effective address size code |
| res_rex_w | output | 1 | REX.W in force |
| res_rex_r | output | 1 | REX.R in force |
| res_rex_x | output | 1 | REX.X in force |
| res_rex_b | output | 1 | REX.B in force |
| res_pfx_err | output | 1 | Prefix run longer than MAX_PFX |

## Verification
The bench uses the default MAX_PFX of 14, which keeps both the 14-byte and the 15-byte prefix runs short enough to drive in a few cycles. For each of the three contexts (64-bit, compatibility 16, compatibility 32), every byte value that is not a prefix is sent as an opcode under all four combinations of 66h and 67h. In 64-bit mode this is repeated with several REX values, which covers every stack-class opcode and the 40h–4Fh reinterpretation. Separate sequences cover REX placement, the error threshold and result back-pressure.

// File: rtl/ipr_pkg.sv
// Shared types for the instruction prefix resolver.
// Size codes are fixed because downstream stages decode them.
package ipr_pkg;
    typedef enum logic [1:0] {
        SZ16 = 2'b00,
        SZ32 = 2'b01,
        SZ64 = 2'b10
    } size_e;

    typedef enum logic [2:0] {
        BC_OPCODE = 3'd0,
        BC_OPSZ   = 3'd1,
        BC_ADSZ   = 3'd2,
        BC_LEGACY = 3'd3,
        BC_REX    = 3'd4
    } byte_cls_e;

    typedef struct packed {
        logic w;
        logic r;
        logic x;
        logic b;
    } rex_t;
endpackage

// File: rtl/ipr_classify.sv
// ipr_classify: combinational sort of one instruction byte.
// Decides whether the byte is the operand-size prefix, the address-size
// prefix, another legacy prefix, a REX byte (64-bit mode only) or an opcode.
// Also flags opcodes of the stack class.
// Assumes: one-byte opcode map only; escapes are treated as plain opcodes.
module ipr_classify
    import ipr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              long_mode,
    output byte_cls_e         cls,
    output logic              stack_op
);
    // Byte category from its value and the current mode
    always_comb begin
        cls = BC_OPCODE;
        case (byte_in)
            8'h66: cls = BC_OPSZ;
            8'h67: cls = BC_ADSZ;
            8'h26, 8'h2E, 8'h36, 8'h3E,
            8'h64, 8'h65, 8'hF0, 8'hF2, 8'hF3: cls = BC_LEGACY;
            default: begin
                if (long_mode && byte_in[7:4] == 4'h4) cls = BC_REX;
            end
        endcase
    end

    // Stack-class opcodes that default to the widest size in 64-bit mode
    always_comb begin
        stack_op = 1'b0;
        if (byte_in[7:4] == 4'h5) stack_op = 1'b1;
        case (byte_in)
            8'h68, 8'h6A, 8'h8F, 8'h9C, 8'h9D, 8'hC8, 8'hC9: stack_op = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ipr_prefix_state.sv
// ipr_prefix_state: holds prefix state between the first prefix and the opcode.
// Tracks 66h/67h presence, the REX bits in force and a saturating count of
// prefix bytes. A legacy prefix after a REX byte drops the REX bits.
// Assumes: take is the qualified byte handshake; state clears on an opcode.
module ipr_prefix_state
    import ipr_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int MAX_PFX = 14,
    localparam int CNT_W  = $clog2(MAX_PFX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  byte_cls_e         cls,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              has66,
    output logic              has67,
    output rex_t              rex,
    output logic [CNT_W-1:0]  pfx_cnt,
    output logic              overflow
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_PFX + 1);

    logic [CNT_W-1:0] cnt_next;

    // Saturating increment of the prefix count
    always_comb begin
        cnt_next = (pfx_cnt == SAT) ? pfx_cnt : pfx_cnt + 1'b1;
    end

    // Prefix state update per accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has66   <= 1'b0;
            has67   <= 1'b0;
            rex     <= '0;
            pfx_cnt <= '0;
        end else if (take) begin
            case (cls)
                BC_OPCODE: begin
                    has66   <= 1'b0;
                    has67   <= 1'b0;
                    rex     <= '0;
                    pfx_cnt <= '0;
                end
                BC_OPSZ: begin
                    has66   <= 1'b1;
                    rex     <= '0;
                    pfx_cnt <= cnt_next;
                end
                BC_ADSZ: begin
                    has67   <= 1'b1;
                    rex     <= '0;
                    pfx_cnt <= cnt_next;
                end
                BC_LEGACY: begin
                    rex     <= '0;
                    pfx_cnt <= cnt_next;
                end
                BC_REX: begin
                    rex     <= rex_t'(byte_in[3:0]);
                    pfx_cnt <= cnt_next;
                end
                default: ;
            endcase
        end
    end

    // Prefix run exceeded the allowed length
    always_comb begin
        overflow = (pfx_cnt > CNT_W'(MAX_PFX));
    end
endmodule

// File: rtl/ipr_size_resolve.sv
// ipr_size_resolve: combinational operand- and address-size selection.
// Combines mode, segment default, 66h, 67h, REX.W and the stack class.
// Assumes: rex_w is already forced low outside 64-bit mode.
module ipr_size_resolve
    import ipr_pkg::*;
(
    input  logic  long_mode,
    input  logic  seg_def32,
    input  logic  has66,
    input  logic  has67,
    input  logic  rex_w,
    input  logic  stack_op,
    output size_e op_size,
    output size_e ad_size
);
    // Operand size: W beats 66h, 66h beats the class default
    always_comb begin
        if (long_mode) begin
            if (rex_w)         op_size = SZ64;
            else if (has66)    op_size = SZ16;
            else if (stack_op) op_size = SZ64;
            else               op_size = SZ32;
        end else begin
            op_size = (seg_def32 ^ has66) ? SZ32 : SZ16;
        end
    end

    // Address size: 67h narrows in 64-bit mode, toggles in compatibility mode
    always_comb begin
        if (long_mode) ad_size = has67 ? SZ32 : SZ64;
        else           ad_size = (seg_def32 ^ has67) ? SZ32 : SZ16;
    end
endmodule

// File: rtl/insn_prefix_resolver.sv
// insn_prefix_resolver: top of the prefix decoder and size resolver.
// Takes one byte per cycle, keeps prefix state until a primary opcode is
// seen, then registers one result record held until the consumer takes it.
// Assumes: long_mode and seg_def32 change only between instructions.
module insn_prefix_resolver
    import ipr_pkg::*;
#(
    parameter int MAX_PFX = 14,
    localparam int BYTE_W = 8,
    localparam int CNT_W  = $clog2(MAX_PFX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_mode,
    input  logic              seg_def32,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ready,
    input  logic              res_ready,
    output logic              res_valid,
    output logic [BYTE_W-1:0] res_opcode,
    output logic [1:0]        res_op_size,
    output logic [1:0]        res_ad_size,
    output logic              res_rex_w,
    output logic              res_rex_r,
    output logic              res_rex_x,
    output logic              res_rex_b,
    output logic              res_pfx_err
);
    byte_cls_e        cls;
    logic             stack_op;
    logic             take;
    logic             take_opcode;
    logic             has66;
    logic             has67;
    rex_t             rex;
    rex_t             rex_eff;
    logic [CNT_W-1:0] pfx_count;
    logic             overflow;
    size_e            op_size;
    size_e            ad_size;

    ipr_classify #(.BYTE_W(BYTE_W)) u_cls (
        .byte_in   (byte_data),
        .long_mode (long_mode),
        .cls       (cls),
        .stack_op  (stack_op)
    );

    ipr_prefix_state #(.BYTE_W(BYTE_W), .MAX_PFX(MAX_PFX)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .cls      (cls),
        .byte_in  (byte_data),
        .has66    (has66),
        .has67    (has67),
        .rex      (rex),
        .pfx_cnt  (pfx_count),
        .overflow (overflow)
    );

    // REX bits apply only in 64-bit mode
    always_comb begin
        rex_eff = long_mode ? rex : '0;
    end

    ipr_size_resolve u_size (
        .long_mode (long_mode),
        .seg_def32 (seg_def32),
        .has66     (has66),
        .has67     (has67),
        .rex_w     (rex_eff.w),
        .stack_op  (stack_op),
        .op_size   (op_size),
        .ad_size   (ad_size)
    );

    // Byte handshake: accept when the result slot is free or being drained
    always_comb begin
        byte_ready  = !res_valid || res_ready;
        take        = byte_valid && byte_ready;
        take_opcode = take && (cls == BC_OPCODE);
    end

    // Result record register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_opcode  <= '0;
            res_op_size <= SZ16;
            res_ad_size <= SZ16;
            res_rex_w   <= 1'b0;
            res_rex_r   <= 1'b0;
            res_rex_x   <= 1'b0;
            res_rex_b   <= 1'b0;
            res_pfx_err <= 1'b0;
        end else if (take_opcode) begin
            res_valid   <= 1'b1;
            res_opcode  <= byte_data;
            res_op_size <= op_size;
            res_ad_size <= ad_size;
            res_rex_w   <= rex_eff.w;
            res_rex_r   <= rex_eff.r;
            res_rex_x   <= rex_eff.x;
            res_rex_b   <= rex_eff.b;
            res_pfx_err <= overflow;
        end else if (res_ready) begin
            res_valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/ipr_checker.sv
// ipr_checker: temporal properties of insn_prefix_resolver, bound to the top.
module ipr_checker #(
    parameter int MAX_PFX = 14,
    localparam int CNT_W  = $clog2(MAX_PFX + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             long_mode,
    input logic             byte_ready,
    input logic             res_ready,
    input logic             res_valid,
    input logic [7:0]       res_opcode,
    input logic [1:0]       res_op_size,
    input logic [1:0]       res_ad_size,
    input logic             res_rex_w,
    input logic             take_opcode,
    input logic [CNT_W-1:0] pfx_count
);
    // R1
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_opcode)
                                    && $stable(res_op_size) && $stable(res_ad_size));

    // R1
    ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> byte_ready);

    // R2
    result_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(take_opcode) |-> res_valid);

    // R3
    rexw_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_rex_w |-> res_op_size == 2'b10);

    // R7
    long_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(take_opcode) && $past(long_mode) |-> res_ad_size != 2'b00);

    // R9
    clear_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(take_opcode) |-> pfx_count == '0);
endmodule

bind insn_prefix_resolver ipr_checker #(.MAX_PFX(MAX_PFX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .long_mode   (long_mode),
    .byte_ready  (byte_ready),
    .res_ready   (res_ready),
    .res_valid   (res_valid),
    .res_opcode  (res_opcode),
    .res_op_size (res_op_size),
    .res_ad_size (res_ad_size),
    .res_rex_w   (res_rex_w),
    .take_opcode (take_opcode),
    .pfx_count   (pfx_count)
);

// File: tb/insn_prefix_resolver_tb.sv
module insn_prefix_resolver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       long_mode = 1'b1;
    logic       seg_def32 = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_ready;
    logic       res_ready = 1'b1;
    logic       res_valid;
    logic [7:0] res_opcode;
    logic [1:0] res_op_size;
    logic [1:0] res_ad_size;
    logic       res_rex_w, res_rex_r, res_rex_x, res_rex_b;
    logic       res_pfx_err;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] pbuf [0:15];
    int         npfx;

    always #10 clk = ~clk;

    insn_prefix_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .seg_def32(seg_def32),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .res_ready(res_ready), .res_valid(res_valid), .res_opcode(res_opcode),
        .res_op_size(res_op_size), .res_ad_size(res_ad_size),
        .res_rex_w(res_rex_w), .res_rex_r(res_rex_r), .res_rex_x(res_rex_x),
        .res_rex_b(res_rex_b), .res_pfx_err(res_pfx_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_legacy(input logic [7:0] b);
        return b == 8'h66 || b == 8'h67 || b == 8'h26 || b == 8'h2E || b == 8'h36 ||
               b == 8'h3E || b == 8'h64 || b == 8'h65 || b == 8'hF0 ||
               b == 8'hF2 || b == 8'hF3;
    endfunction

    function automatic bit is_stack(input logic [7:0] b);
        return (b >= 8'h50 && b <= 8'h5F) || b == 8'h68 || b == 8'h6A ||
               b == 8'h8F || b == 8'h9C || b == 8'h9D || b == 8'hC8 || b == 8'hC9;
    endfunction

    // Send pbuf[0..npfx-1] then opcode, and compare the result record
    task automatic send_insn(input logic [7:0] op, input string tag);
        bit         p66 = 0, p67 = 0;
        logic [3:0] rx = 4'h0;
        int         eo, ea;
        for (int i = 0; i < npfx; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = pbuf[i];
            if (long_mode && pbuf[i][7:4] == 4'h4) rx = pbuf[i][3:0];
            else begin
                rx = 4'h0;
                if (pbuf[i] == 8'h66) p66 = 1;
                if (pbuf[i] == 8'h67) p67 = 1;
            end
        end
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = op;
        @(negedge clk);
        byte_valid = 1'b0;
        if (long_mode) begin
            if (rx[3])             eo = 2;
            else if (p66)          eo = 0;
            else if (is_stack(op)) eo = 2;
            else                   eo = 1;
            ea = p67 ? 1 : 2;
        end else begin
            eo = (seg_def32 ^ p66) ? 1 : 0;
            ea = (seg_def32 ^ p67) ? 1 : 0;
        end
        check({"R2 valid ", tag}, res_valid, 1);
        check({"R2 opcode ", tag}, res_opcode, op);
        check({(long_mode ? (is_stack(op) ? "R4" : "R3") : "R6"), " opsize ", tag},
              res_op_size, eo);
        check({"R7 adsize ", tag}, res_ad_size, ea);
        check({(long_mode ? "R8" : "R5"), " rex ", tag},
              {res_rex_w, res_rex_r, res_rex_x, res_rex_b}, rx);
        check({"R10 err ", tag}, res_pfx_err, npfx > 14);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int rxl [5];
        rxl = '{-1, 'h48, 'h40, 'h47, 'h4F};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset res_valid", res_valid, 0);
        check("R1 reset byte_ready", byte_ready, 1);

        // Sweep: every non-prefix opcode in each context with prefix combinations
        for (int md = 0; md < 3; md++) begin
            long_mode = (md == 0);
            seg_def32 = (md == 2);
            for (int op = 0; op < 256; op++) begin
                if (is_legacy(8'(op))) continue;
                if (long_mode && op[7:4] == 4'h4) continue;
                for (int pc = 0; pc < 4; pc++) begin
                    for (int r = 0; r < (long_mode ? 5 : 1); r++) begin
                        npfx = 0;
                        if (pc[0]) begin pbuf[npfx] = 8'h66; npfx++; end
                        if (pc[1]) begin pbuf[npfx] = 8'h67; npfx++; end
                        if (rxl[r] >= 0) begin pbuf[npfx] = 8'(rxl[r]); npfx++; end
                        send_insn(8'(op), "sweep R9");
                    end
                end
            end
        end

        // R8: legacy prefix after REX discards it; later REX replaces earlier
        long_mode = 1'b1;
        npfx = 2; pbuf[0] = 8'h4F; pbuf[1] = 8'h66;
        send_insn(8'h89, "R8 rex-then-66");
        npfx = 2; pbuf[0] = 8'h48; pbuf[1] = 8'h41;
        send_insn(8'h01, "R8 rex-replace");
        npfx = 2; pbuf[0] = 8'h48; pbuf[1] = 8'h66;
        send_insn(8'h50, "R4 rex-then-66 stack");

        // R10: threshold at exactly MAX_PFX and one over
        npfx = 14;
        for (int i = 0; i < 14; i++) pbuf[i] = 8'hF3;
        send_insn(8'h90, "R10 14 prefixes");
        npfx = 15;
        for (int i = 0; i < 15; i++) pbuf[i] = (i == 14) ? 8'h48 : 8'h2E;
        send_insn(8'h90, "R10 15 prefixes");
        npfx = 0;
        send_insn(8'h90, "R9 after error");

        // R1: back-pressure holds the result and blocks bytes
        @(negedge clk);
        res_ready  = 1'b0;
        byte_valid = 1'b1;
        byte_data  = 8'hAA;
        @(negedge clk);
        byte_data = 8'hBB;
        repeat (3) @(negedge clk);
        check("R1 held valid", res_valid, 1);
        check("R1 held opcode", res_opcode, 8'hAA);
        check("R1 ready low", byte_ready, 0);
        res_ready = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        check("R1 drained next opcode", res_opcode, 8'hBB);
        @(negedge clk);
        check("R1 valid drops", res_valid, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule